// File: doc/BRIEF.md
# Word-Strided UART Core with Offset Baud Divisor

This block is a byte-oriented serial port for a memory-mapped register bus. Software programs a 16-bit divisor, queues characters into a four-entry transmit queue and drains a four-entry receive queue. Each register occupies its own 32-bit word. Two word slots are shared between the divisor bytes and the normal data and interrupt-enable registers. The top bit of the line control register picks which of the two is reached.

A shared oversampling tick fires once every (divisor + 2) clock cycles, so one serial bit lasts 16 × (divisor + 2) cycles. The transmitter sends 8 data bits with no parity and one stop bit. The receiver checks each frame's start bit at its midpoint and records framing and overrun errors in the line status register. Reading line status clears both error flags. Interrupt enable, modem control and timeout values are only held and read back. They drive nothing.

Top module: `uart16_core`

## Requirements
- R1: After reset, txd is 1, line status (word 5, byte offset 0x14) reads 0x60, line control reads 0x00, interrupt id reads 0x01 and both divisor bytes read 0x00.
- R2: When line control bit 7 is 1, word 0 reads and writes the divisor low byte and word 1 reads and writes the divisor high byte. When bit 7 is 0, word 1 is interrupt-enable storage, and writing it leaves the divisor unchanged.
- R3: With divisor D, every serial bit lasts exactly 16 × (D + 2) clock cycles.
- R4: A byte written to word 0 while bit 7 is 0 is sent as one low start bit, then 8 data bits LSB first, then one high stop bit. Between frames the line stays high.
- R5: Line status bit 5 is 1 exactly when the transmit queue is empty. Bit 6 is 1 when the queue is empty and no frame is being shifted out.
- R6: The transmit queue holds 4 characters. A write to word 0 while the queue is full is dropped, and that character is never sent.
- R7: A correctly framed character on rxd is queued. Line status bit 0 is 1 while the receive queue is non-empty, and each read of word 0 returns the oldest entry and removes it.
- R8: A character whose stop bit samples low is still queued and sets line status bit 3.
- R9: A character that arrives while the receive queue holds 4 entries is discarded and sets line status bit 1. A read of line status clears bits 1 and 3.
- R10: A write to word 2 with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue. These bits are not stored. A character already being shifted out finishes.
- R11: A read of word 2 returns 0x01 when the last write to word 2 had bit 0 clear, and 0xC1 when it had bit 0 set.
- R12: Line control (word 3), modem control (word 4) and timeout (word 7) read back the last value written, and modem status (word 6) reads 0. An access whose two low address bits are not both zero writes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address. Bits 4:2 select the register word |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_re | input | 1 | Read strobe. Read side effects take place on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr and current state |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |

## Verification
Read data is combinational, so the bench samples it a moment after it drives the address and read strobe on a falling edge. The pop or flag clear caused by that read shows up on the next access. A transmit write is picked up by the next tick, which comes within D + 2 cycles. The start bit then lasts exactly 16 × (D + 2) cycles, so the bench measures it by counting falling edges from the first low sample. It samples each data and stop bit at its centre, 8 × (D + 2) cycles into the bit. A received character is queued at the centre of its stop bit, after two synchronizer flops. The bench reads status only after the whole stop bit plus a margin, and it runs transmit decoding in parallel with the bus writes so that no start edge is missed.

// File: rtl/uart16_pkg.sv
package uart16_pkg;

    localparam int DATA_W      = 8;
    localparam int DIV_W       = 2 * DATA_W;
    localparam int OVERSAMPLE  = 16;
    localparam int BUS_ADDR_W  = 5;

    typedef enum logic [2:0] {
        REG_DATA = 3'd0,
        REG_IEN  = 3'd1,
        REG_FIFO = 3'd2,
        REG_LCTL = 3'd3,
        REG_MCTL = 3'd4,
        REG_LSTA = 3'd5,
        REG_MSTA = 3'd6,
        REG_TOUT = 3'd7
    } reg_idx_e;

    localparam int LCTL_BANK_BIT = 7;
    localparam int FCTL_EN_BIT   = 0;
    localparam int FCTL_RXCLR    = 1;
    localparam int FCTL_TXCLR    = 2;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_st_e;

    typedef struct packed {
        logic tx_quiet;
        logic tx_room;
        logic frame_err;
        logic overrun;
        logic rx_ready;
    } line_stat_t;

    function automatic logic [DATA_W-1:0] pack_status(line_stat_t s);
        return {1'b0, s.tx_quiet, s.tx_room, 1'b0, s.frame_err, 1'b0, s.overrun, s.rx_ready};
    endfunction

    function automatic logic [DATA_W-1:0] pack_ident(logic fifo_on);
        return {fifo_on, fifo_on, 5'b00000, 1'b1};
    endfunction

endpackage

// File: rtl/uart16_baud.sv
module uart16_baud
    import uart16_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] divisor,
    output logic          tick
);
    logic [DW:0] cnt;
    logic [DW:0] last;

    assign last = {1'b0, divisor} + (DW+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + (DW+1)'(1);
            tick <= 1'b0;
        end
    end

    // R3: period is at least two cycles, so ticks never come back to back
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);

endmodule

// File: rtl/uart16_fifo.sv
module uart16_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // R6: occupancy never exceeds the depth
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst) cnt <= (AW+1)'(DEPTH));
    // R6: a push into a full queue without a pop leaves it full
    a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> full);
    // R10: a clear empties the queue on the next cycle
    a_r10_clr_empty: assert property (@(posedge clk) disable iff (rst) clr |=> empty);

endmodule

// File: rtl/uart16_tx.sv
module uart16_tx
    import uart16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_data,
    output logic              q_pop,
    output logic              txd,
    output logic              busy
);
    localparam int TW = $clog2(OVERSAMPLE);
    localparam logic [TW-1:0] LAST = TW'(OVERSAMPLE - 1);

    line_st_e          st;
    logic [TW-1:0]     tcnt;
    logic [2:0]        bidx;
    logic [DATA_W-1:0] shr;

    assign q_pop = (st == LN_IDLE) && tick && !q_empty;
    assign busy  = (st != LN_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LN_IDLE;
            txd  <= 1'b1;
            tcnt <= '0;
            bidx <= '0;
            shr  <= '0;
        end else if (tick) begin
            case (st)
                LN_IDLE: begin
                    if (!q_empty) begin
                        shr  <= q_data;
                        st   <= LN_START;
                        txd  <= 1'b0;
                        tcnt <= '0;
                    end
                end
                LN_START: begin
                    if (tcnt == LAST) begin
                        st   <= LN_DATA;
                        txd  <= shr[0];
                        bidx <= '0;
                        tcnt <= '0;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                LN_DATA: begin
                    if (tcnt == LAST) begin
                        tcnt <= '0;
                        if (bidx == 3'd7) begin
                            st  <= LN_STOP;
                            txd <= 1'b1;
                        end else begin
                            bidx <= bidx + 3'd1;
                            shr  <= shr >> 1;
                            txd  <= shr[1];
                        end
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                default: begin
                    if (tcnt == LAST) begin
                        st <= LN_IDLE;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
            endcase
        end
    end

    // R4: taking a character from the queue starts a low start bit
    a_r4_start_low: assert property (@(posedge clk) disable iff (rst) q_pop |=> (!txd && busy));

endmodule

// File: rtl/uart16_rx.sv
module uart16_rx
    import uart16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    output logic              got,
    output logic [DATA_W-1:0] data,
    output logic              bad_stop
);
    localparam int TW = $clog2(OVERSAMPLE);
    localparam logic [TW-1:0] HALF = TW'(OVERSAMPLE/2 - 1);
    localparam logic [TW-1:0] LAST = TW'(OVERSAMPLE - 1);

    logic [1:0]    sync;
    logic          prev;
    logic          line;
    logic          fall;
    line_st_e      st;
    logic [TW-1:0] tcnt;
    logic [2:0]    bidx;

    assign line = sync[1];
    assign fall = prev && !line;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
            prev <= 1'b1;
        end else begin
            sync <= {sync[0], rxd};
            prev <= line;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= LN_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            data     <= '0;
            got      <= 1'b0;
            bad_stop <= 1'b0;
        end else begin
            got <= 1'b0;
            case (st)
                LN_IDLE: begin
                    if (fall) begin
                        st   <= LN_START;
                        tcnt <= '0;
                    end
                end
                LN_START: begin
                    if (tick) begin
                        if (tcnt == HALF) begin
                            tcnt <= '0;
                            bidx <= '0;
                            st   <= line ? LN_IDLE : LN_DATA;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                end
                LN_DATA: begin
                    if (tick) begin
                        if (tcnt == LAST) begin
                            tcnt <= '0;
                            data <= {line, data[DATA_W-1:1]};
                            if (bidx == 3'd7) st <= LN_STOP;
                            else              bidx <= bidx + 3'd1;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (tcnt == LAST) begin
                            got      <= 1'b1;
                            bad_stop <= !line;
                            st       <= LN_IDLE;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                end
            endcase
        end
    end

    // R7: a received character is reported for a single cycle
    a_r7_got_pulse: assert property (@(posedge clk) disable iff (rst) got |=> !got);

endmodule

// File: rtl/uart16_core.sv
module uart16_core
    import uart16_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic                  bus_re,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  rxd,
    output logic                  txd
);
    logic [DATA_W-1:0] div_lo, div_hi, ien_q, lctl_q, mctl_q, tout_q;
    logic              fifo_on, fe_flag, oe_flag;
    logic              aligned, bank;
    reg_idx_e          idx;
    logic              tick;

    logic              txq_push, txq_pop, txq_empty, txq_full, txq_clr, tx_busy;
    logic [DATA_W-1:0] txq_dout;
    logic              rxq_pop, rxq_empty, rxq_full, rxq_clr;
    logic [DATA_W-1:0] rxq_dout;
    logic              rx_got, rx_bad;
    logic [DATA_W-1:0] rx_data;
    logic              wr_ok, rd_ok, stat_rd;
    line_stat_t        stat;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = reg_idx_e'(bus_addr[4:2]);
    assign bank    = lctl_q[LCTL_BANK_BIT];
    assign wr_ok   = bus_we && aligned;
    assign rd_ok   = bus_re && aligned;

    assign txq_push = wr_ok && (idx == REG_DATA) && !bank;
    assign rxq_pop  = rd_ok && (idx == REG_DATA) && !bank;
    assign txq_clr  = wr_ok && (idx == REG_FIFO) && bus_wdata[FCTL_TXCLR];
    assign rxq_clr  = wr_ok && (idx == REG_FIFO) && bus_wdata[FCTL_RXCLR];
    assign stat_rd  = rd_ok && (idx == REG_LSTA);

    uart16_baud #(.DW(DIV_W)) baud_i (
        .clk     (clk),
        .rst     (rst),
        .divisor ({div_hi, div_lo}),
        .tick    (tick)
    );

    uart16_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) txq_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (txq_clr),
        .push  (txq_push),
        .din   (bus_wdata),
        .pop   (txq_pop),
        .dout  (txq_dout),
        .empty (txq_empty),
        .full  (txq_full)
    );

    uart16_tx tx_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .q_empty (txq_empty),
        .q_data  (txq_dout),
        .q_pop   (txq_pop),
        .txd     (txd),
        .busy    (tx_busy)
    );

    uart16_rx rx_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .rxd      (rxd),
        .got      (rx_got),
        .data     (rx_data),
        .bad_stop (rx_bad)
    );

    uart16_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) rxq_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (rxq_clr),
        .push  (rx_got),
        .din   (rx_data),
        .pop   (rxq_pop),
        .dout  (rxq_dout),
        .empty (rxq_empty),
        .full  (rxq_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_lo  <= '0;
            div_hi  <= '0;
            ien_q   <= '0;
            lctl_q  <= '0;
            mctl_q  <= '0;
            tout_q  <= '0;
            fifo_on <= 1'b0;
        end else if (wr_ok) begin
            case (idx)
                REG_DATA: if (bank) div_lo <= bus_wdata;
                REG_IEN:  if (bank) div_hi <= bus_wdata;
                          else      ien_q  <= bus_wdata;
                REG_FIFO: fifo_on <= bus_wdata[FCTL_EN_BIT];
                REG_LCTL: lctl_q  <= bus_wdata;
                REG_MCTL: mctl_q  <= bus_wdata;
                REG_TOUT: tout_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fe_flag <= 1'b0;
            oe_flag <= 1'b0;
        end else begin
            if (rx_got && rx_bad)        fe_flag <= 1'b1;
            else if (stat_rd)            fe_flag <= 1'b0;
            if (rx_got && rxq_full)      oe_flag <= 1'b1;
            else if (stat_rd)            oe_flag <= 1'b0;
        end
    end

    always_comb begin
        stat.rx_ready  = !rxq_empty;
        stat.overrun   = oe_flag;
        stat.frame_err = fe_flag;
        stat.tx_room   = txq_empty;
        stat.tx_quiet  = txq_empty && !tx_busy;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                REG_DATA: bus_rdata = bank ? div_lo : rxq_dout;
                REG_IEN:  bus_rdata = bank ? div_hi : ien_q;
                REG_FIFO: bus_rdata = pack_ident(fifo_on);
                REG_LCTL: bus_rdata = lctl_q;
                REG_MCTL: bus_rdata = mctl_q;
                REG_LSTA: bus_rdata = pack_status(stat);
                REG_MSTA: bus_rdata = '0;
                default:  bus_rdata = tout_q;
            endcase
        end
    end

    // R9: a status read with no new character arriving leaves both error flags clear
    a_r9_flags_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !rx_got) |=> (!fe_flag && !oe_flag));
    // R8: a character with a low stop bit raises the framing flag
    a_r8_fe_set: assert property (@(posedge clk) disable iff (rst)
        (rx_got && rx_bad) |=> fe_flag);

endmodule

// File: tb/uart16_core_tb_top.sv
module uart16_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr = '0;
    logic       we = 1'b0;
    logic       re = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    uart16_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_re    (re),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .rxd       (rxd),
        .txd       (txd)
    );

    localparam logic [4:0] A_DATA = 5'h00, A_IEN = 5'h04, A_FIFO = 5'h08, A_LCTL = 5'h0C,
                           A_MCTL = 5'h10, A_LSTA = 5'h14, A_MSTA = 5'h18, A_TOUT = 5'h1C;

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        #2 d = rdata;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic set_div(input logic [15:0] d);
        wr(A_LCTL, 8'h83);
        wr(A_DATA, d[7:0]);
        wr(A_IEN, d[15:8]);
        wr(A_LCTL, 8'h03);
    endtask

    task automatic tx_grab(input int p, output logic [7:0] b, output logic framed);
        int waited = 0;
        logic st_ok;
        b = '0;
        framed = 1'b0;
        @(negedge clk);
        while (txd !== 1'b0 && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        repeat (8*p) @(negedge clk);
        st_ok = (txd === 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (16*p) @(negedge clk);
            b[i] = txd;
        end
        repeat (16*p) @(negedge clk);
        framed = st_ok && (txd === 1'b1);
    endtask

    task automatic rx_send(input logic [7:0] b, input logic stop_bit, input int p);
        logic [9:0] fr;
        fr = {stop_bit, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rxd = fr[i];
            repeat (16*p - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (16*p) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 txd idle", int'(txd), 1);
        rd(A_LSTA, v); check("R1 status", v, 8'h60);
        rd(A_LCTL, v); check("R1 line ctl", v, 8'h00);
        rd(A_FIFO, v); check("R1 ident", v, 8'h01);
        wr(A_LCTL, 8'h80);
        rd(A_DATA, v); check("R1 div lo", v, 8'h00);
        rd(A_IEN, v);  check("R1 div hi", v, 8'h00);
        wr(A_LCTL, 8'h03);
    endtask

    task automatic t_bank;
        logic [7:0] v;
        set_div(16'h1234);
        wr(A_IEN, 8'h0F);
        rd(A_IEN, v); check("R2 ien store", v, 8'h0F);
        wr(A_LCTL, 8'h83);
        rd(A_DATA, v); check("R2 div lo", v, 8'h34);
        rd(A_IEN, v);  check("R2 div hi kept", v, 8'h12);
        wr(A_LCTL, 8'h03);
        rd(A_IEN, v); check("R2 ien back", v, 8'h0F);
    endtask

    task automatic t_bitlen(input logic [15:0] d);
        int width = 0;
        int waited = 0;
        set_div(d);
        wr(A_DATA, 8'h55);
        @(negedge clk);
        while (txd !== 1'b0 && waited < 20000) begin @(negedge clk); waited++; end
        while (txd === 1'b0 && width < 20000) begin @(negedge clk); width++; end
        check("R3 start bit length", width, 16 * (int'(d) + 2));
        repeat (16 * (int'(d) + 2) * 10) @(negedge clk);
    endtask

    task automatic t_frame;
        logic [7:0] b;
        logic f;
        fork
            wr(A_DATA, 8'hA5);
            tx_grab(2, b, f);
        join
        check("R4 tx byte", b, 8'hA5);
        check("R4 framing", int'(f), 1);
    endtask

    task automatic t_status;
        logic [7:0] b0, b1, v0, v1;
        logic f0, f1;
        fork
            begin
                wr(A_DATA, 8'h3C);
                wr(A_DATA, 8'hC3);
                rd(A_LSTA, v0);
            end
            begin
                tx_grab(2, b0, f0);
                tx_grab(2, b1, f1);
                rd(A_LSTA, v1);
            end
        join
        check("R5 status queued", v0, 8'h00);
        check("R5 status last shifting", v1, 8'h20);
        check("R5 order", {b0, b1}, 16'h3CC3);
        repeat (40) @(negedge clk);
        rd(A_LSTA, v0); check("R5 status quiet", v0, 8'h60);
    endtask

    task automatic t_txfull;
        logic [7:0] got [5];
        logic f;
        int lows = 0;
        fork
            for (int i = 0; i < 7; i++) wr(A_DATA, 8'h11 + 8'(i));
            for (int i = 0; i < 5; i++) tx_grab(2, got[i], f);
        join
        for (int i = 0; i < 5; i++) check("R6 sent", got[i], 8'h11 + i);
        repeat (400) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check("R6 dropped chars not sent", lows, 0);
    endtask

    task automatic t_rx;
        logic [7:0] v;
        rx_send(8'h3C, 1'b1, 2);
        rd(A_LSTA, v); check("R7 ready", v, 8'h61);
        rd(A_DATA, v); check("R7 data", v, 8'h3C);
        rd(A_LSTA, v); check("R7 drained", v, 8'h60);
    endtask

    task automatic t_frame_err;
        logic [7:0] v;
        rx_send(8'h81, 1'b0, 2);
        rd(A_LSTA, v); check("R8 framing flag", v, 8'h69);
        rd(A_LSTA, v); check("R9 flag cleared by read", v, 8'h61);
        rd(A_DATA, v); check("R8 data kept", v, 8'h81);
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        for (int i = 0; i < 5; i++) rx_send(8'hA0 + 8'(i), 1'b1, 2);
        rd(A_LSTA, v); check("R9 overrun flag", v, 8'h63);
        rd(A_LSTA, v); check("R9 overrun cleared", v, 8'h61);
        for (int i = 0; i < 4; i++) begin
            rd(A_DATA, v); check("R9 kept oldest", v, 8'hA0 + i);
        end
        rd(A_LSTA, v); check("R9 empty after four", v, 8'h60);
    endtask

    task automatic t_clear;
        logic [7:0] v, s, b;
        logic f;
        int lows = 0;
        rx_send(8'h01, 1'b1, 2);
        rx_send(8'h02, 1'b1, 2);
        wr(A_FIFO, 8'h03);
        rd(A_LSTA, v); check("R10 rx cleared", v, 8'h60);
        fork
            begin
                wr(A_DATA, 8'h71);
                wr(A_DATA, 8'h72);
                wr(A_DATA, 8'h73);
                wr(A_FIFO, 8'h05);
                rd(A_LSTA, s);
                rd(A_FIFO, v);
            end
            tx_grab(2, b, f);
        join
        check("R10 tx cleared, shifter busy", s, 8'h20);
        check("R11 ident enabled", v, 8'hC1);
        check("R10 frame in flight finishes", b, 8'h71);
        repeat (400) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check("R10 cleared chars not sent", lows, 0);
        wr(A_FIFO, 8'h00);
        rd(A_FIFO, v); check("R11 ident disabled", v, 8'h01);
    endtask

    task automatic t_storage;
        logic [7:0] v;
        wr(A_LCTL, 8'h1B);
        rd(A_LCTL, v); check("R12 line ctl", v, 8'h1B);
        wr(A_LCTL, 8'h03);
        wr(A_MCTL, 8'h0F);
        rd(A_MCTL, v); check("R12 modem ctl", v, 8'h0F);
        wr(A_TOUT, 8'h5A);
        rd(A_TOUT, v); check("R12 timeout", v, 8'h5A);
        rd(A_MSTA, v); check("R12 modem status", v, 8'h00);
        wr(5'h0D, 8'hFF);
        rd(A_LCTL, v); check("R12 unaligned write ignored", v, 8'h03);
        rd(5'h0D, v);  check("R12 unaligned read zero", v, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bank();
        t_bitlen(16'd3);
        set_div(16'd0);
        repeat (40) @(negedge clk);
        t_frame();
        t_status();
        t_txfull();
        t_rx();
        t_frame_err();
        t_overrun();
        t_clear();
        t_storage();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule